// File: doc/BRIEF.md
# Configurable UART Serial Engine

This block is the serial core of a classic asynchronous serial port. It turns bytes written by a host into framed serial characters on `txd`. It also rebuilds characters arriving on `rxd` into bytes for the host to read. A 16-bit divisor sets the bit rate. The divisor is programmed one byte at a time, and it makes a tick that runs at sixteen times the bit rate. A five-bit configuration word sets the frame format: character length, stop bits, parity enable and parity sense. The same word applies to both directions.

Each direction is double-buffered. A holding register sits in front of the transmit shift register, and a buffer register sits behind the receive shift register. The host can therefore write the next byte, or read the last one, while a character is still being shifted. Characters shorter than eight bits are kept toward bit 0. Status outputs show when a received character is waiting, when the holding register is free, and when the transmitter is completely quiet. Separate flags report parity, framing and overrun errors.

Top module: `uart_engine`

## Requirements
- R1: The tick period equals the divisor value in clock cycles, and one bit lasts 16 ticks. A divisor of zero stops the tick: a byte that is written stays in the holding register (`holdEmpty` low) and `txd` stays high. Reset clears the divisor to zero.
- R2: A pulse on `divLoWr` loads `wrData` into divisor bits 7:0. A pulse on `divHiWr` loads `wrData` into divisor bits 15:8.
- R3: `lineCfg[1:0]` selects the character length: 00, 01, 10 and 11 give 5, 6, 7 and 8 bits. `lineCfg[2]` adds a second stop bit, `lineCfg[3]` enables parity and `lineCfg[4]` selects even parity (0 selects odd). Every frame starts with one low start bit.
- R4: Bit 0 is the first data bit on the line in both directions. A received character shorter than 8 bits appears right-justified on `rxData`, and its unused upper bits read 0.
- R5: With parity enabled, the parity bit follows the last data bit. It makes the count of ones in the data bits plus the parity bit even (even parity) or odd (odd parity).
- R6: The stop period is high for 16 ticks, or 32 ticks when `lineCfg[2]` is set. When `lineCfg[2]` is set with a 5-bit length, the stop period is 24 ticks.
- R7: `holdEmpty` rises when the held byte moves into the shift register, which is the cycle before the start bit appears on `txd`. `txEmpty` rises only after the final stop period has ended with nothing held. While `txEmpty` is high, `txd` is high.
- R8: A byte written while a character is being shifted does not disturb that character. It leaves on the line right after the previous stop period, with no idle gap.
- R9: The receiver starts on a high-to-low change of `rxd`. It re-checks the line at the 8th tick and goes back to idle if the line is high again, so a low pulse shorter than half a bit produces no character. Later bits are sampled at 16-tick intervals from that point.
- R10: When the first stop bit has been sampled, the character is written to `rxData` and `rxReady` goes high. A pulse on `rxTake` clears `rxReady`.
- R11: `parityErr` is set when the received parity bit does not match the selected sense. `framingErr` is set when the first stop bit samples low. In both cases the character is still delivered. A pulse on `errClr` clears both flags and `overrun`.
- R12: `overrun` is set when a character completes while `rxReady` is still high and no `rxTake` arrives in the same cycle. The new character replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrData | input | 8 | Write data for the divisor bytes and the transmit holding register |
| divLoWr | input | 1 | Load divisor low byte |
| divHiWr | input | 1 | Load divisor high byte |
| txHoldWr | input | 1 | Write a byte into the transmit holding register |
| rxTake | input | 1 | Host has read `rxData`; clears `rxReady` |
| errClr | input | 1 | Clears parity, framing and overrun flags |
| lineCfg | input | 5 | Frame format: length[1:0], two stop[2], parity on[3], even[4] |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| rxData | output | 8 | Last received character, right-justified |
| rxReady | output | 1 | Unread character present |
| holdEmpty | output | 1 | Transmit holding register can take a byte |
| txEmpty | output | 1 | Holding and shift registers both empty, line idle |
| parityErr | output | 1 | Parity mismatch seen |
| framingErr | output | 1 | Stop bit sampled low |
| overrun | output | 1 | Unread character was overwritten |

## Verification
The properties assume that `lineCfg` and the divisor do not change while a character is being sent or received. They also assume each strobe is a single-cycle pulse. Under those conditions, the error flags can only rise together with a delivered character, `rxReady` can only fall after a take, and an idle transmitter holds the line high. The stimulus follows the same rules. It reprograms the divisor and the format only while both directions are idle, and it drives `rxd` with whole bit times at the programmed rate. The one exception is the deliberate short glitch.

// File: rtl/uart_eng_pkg.sv
package uart_eng_pkg;

  localparam int BYTE_W = 8;
  localparam int OVS_W  = 4;   // 16 ticks per bit

  typedef enum logic [1:0] {
    LINE_MARK  = 2'd0,
    LINE_START = 2'd1,
    LINE_DATA  = 2'd2,
    LINE_PAR   = 2'd3
  } lineSel_e;

  // strobes from the sequencing logic to the data registers
  typedef struct packed {
    logic     txLoad;       // holding register -> shift register
    logic     txShift;      // advance transmit shift register
    lineSel_e txSel;        // what drives the serial output
    logic     rxStart;      // clear receive shift register
    logic     rxShift;      // shift in one sampled data bit
    logic     rxParSample;  // capture sampled parity bit
    logic     rxDone;       // first stop bit sampled now
  } engStrobe_t;

  function automatic logic [3:0] charBits(input logic [1:0] lenCode);
    return 4'd5 + {2'b00, lenCode};
  endfunction

endpackage

// File: rtl/uart_eng_ctrl.sv
module uart_eng_ctrl
  import uart_eng_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              divLoWr,
  input  logic              divHiWr,
  input  logic [4:0]        lineCfg,
  input  logic              holdFull,
  input  logic              rxLine,
  output engStrobe_t        strobe,
  output logic              txIdle
);

  localparam int HI_W = DIV_W - BYTE_W;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2} txState_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rxState_e;

  // ---------------- baud tick ----------------
  logic [DIV_W-1:0] divReg, divCnt;
  logic             tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= '0;
    end else begin
      if (divLoWr) divReg[BYTE_W-1:0] <= wrData;
      if (divHiWr) divReg[DIV_W-1:BYTE_W] <= wrData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (divReg == '0 || divCnt >= divReg - DIV_W'(1)) divCnt <= '0;
    else divCnt <= divCnt + DIV_W'(1);
  end

  assign tick = (divReg != '0) && (divCnt == divReg - DIV_W'(1));

  // ---------------- shared format decode ----------------
  logic [2:0] lastBit;
  logic       twoStop, parEn, fiveBit;

  assign lastBit = 3'(charBits(lineCfg[1:0]) - 4'd1);
  assign twoStop = lineCfg[2];
  assign parEn   = lineCfg[3];
  assign fiveBit = (lineCfg[1:0] == 2'b00);

  // ---------------- transmit sequencing ----------------
  txState_e         txState;
  logic [OVS_W-1:0] txTicks, txLast;
  logic [2:0]       txBit;
  logic             txBitEnd, txFinal;

  assign txLast   = (txState == TX_STOP2 && fiveBit) ? 4'd7 : 4'd15;
  assign txBitEnd = tick && (txTicks == txLast);
  assign txFinal  = (txState == TX_STOP1 && !twoStop) || (txState == TX_STOP2);
  assign txIdle   = (txState == TX_IDLE);

  // ---------------- receive sequencing ----------------
  rxState_e         rxState;
  logic [OVS_W-1:0] rxTicks;
  logic [2:0]       rxBit;
  logic             rxPrev, rxMid;

  assign rxMid = tick && (rxTicks == 4'd15);

  always_comb begin
    strobe = '0;
    unique case (txState)
      TX_START: strobe.txSel = LINE_START;
      TX_DATA:  strobe.txSel = LINE_DATA;
      TX_PAR:   strobe.txSel = LINE_PAR;
      default:  strobe.txSel = LINE_MARK;
    endcase
    strobe.txLoad      = holdFull && tick && (txIdle || (txBitEnd && txFinal));
    strobe.txShift     = txBitEnd && (txState == TX_DATA);
    strobe.rxStart     = (rxState == RX_IDLE) && rxPrev && !rxLine;
    strobe.rxShift     = (rxState == RX_DATA) && rxMid;
    strobe.rxParSample = (rxState == RX_PAR) && rxMid;
    strobe.rxDone      = (rxState == RX_STOP) && rxMid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txTicks <= '0;
      txBit   <= '0;
    end else begin
      if (!txIdle && tick) txTicks <= txBitEnd ? '0 : txTicks + 1'b1;
      unique case (txState)
        TX_IDLE:  if (strobe.txLoad) begin txState <= TX_START; txTicks <= '0; end
        TX_START: if (txBitEnd) begin txState <= TX_DATA; txBit <= '0; end
        TX_DATA:  if (txBitEnd) begin
                    if (txBit == lastBit) txState <= parEn ? TX_PAR : TX_STOP1;
                    else txBit <= txBit + 1'b1;
                  end
        TX_PAR:   if (txBitEnd) txState <= TX_STOP1;
        TX_STOP1: if (txBitEnd) txState <= twoStop ? TX_STOP2 : (strobe.txLoad ? TX_START : TX_IDLE);
        TX_STOP2: if (txBitEnd) txState <= strobe.txLoad ? TX_START : TX_IDLE;
        default:  txState <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTicks <= '0;
      rxBit   <= '0;
      rxPrev  <= 1'b1;
    end else begin
      rxPrev <= rxLine;
      unique case (rxState)
        RX_IDLE: if (strobe.rxStart) begin rxState <= RX_START; rxTicks <= '0; end
        RX_START: if (tick) begin
                    if (rxTicks == 4'd7) begin
                      rxTicks <= '0;
                      rxBit   <= '0;
                      rxState <= rxLine ? RX_IDLE : RX_DATA;
                    end else rxTicks <= rxTicks + 1'b1;
                  end
        RX_DATA: begin
                   if (tick) rxTicks <= rxTicks + 1'b1;
                   if (rxMid) begin
                     if (rxBit == lastBit) rxState <= parEn ? RX_PAR : RX_STOP;
                     else rxBit <= rxBit + 1'b1;
                   end
                 end
        RX_PAR: begin
                  if (tick) rxTicks <= rxTicks + 1'b1;
                  if (rxMid) rxState <= RX_STOP;
                end
        RX_STOP: begin
                   if (tick) rxTicks <= rxTicks + 1'b1;
                   if (rxMid) rxState <= RX_IDLE;
                 end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_eng_dpath.sv
module uart_eng_dpath
  import uart_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        strobe,
  input  logic [4:0]        lineCfg,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              txHoldWr,
  input  logic              rxTake,
  input  logic              errClr,
  input  logic              rxd,
  output logic              txd,
  output logic              rxLine,
  output logic              holdFull,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              framingErr,
  output logic              overrun
);

  logic [3:0]        nBits;
  logic [BYTE_W-1:0] lenMask, holdReg, txSh, txMasked, rxSh, rxWord;
  logic              txPar, rxParBit, rxMeta, evenPar, parEn, parExp;

  assign nBits    = charBits(lineCfg[1:0]);
  assign lenMask  = 8'hFF >> (4'd8 - nBits);
  assign parEn    = lineCfg[3];
  assign evenPar  = lineCfg[4];
  assign txMasked = holdReg & lenMask;
  assign rxWord   = rxSh >> (4'd8 - nBits);
  assign parExp   = evenPar ? ^rxWord : ~^rxWord;

  // transmit holding and shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      txSh     <= '0;
      txPar    <= 1'b0;
      txd      <= 1'b1;
    end else begin
      if (txHoldWr) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end else if (strobe.txLoad) begin
        holdFull <= 1'b0;
      end
      if (strobe.txLoad) begin
        txSh  <= txMasked;
        txPar <= evenPar ? ^txMasked : ~^txMasked;
      end else if (strobe.txShift) begin
        txSh <= txSh >> 1;
      end
      unique case (strobe.txSel)
        LINE_START: txd <= 1'b0;
        LINE_DATA:  txd <= txSh[0];
        LINE_PAR:   txd <= txPar;
        default:    txd <= 1'b1;
      endcase
    end
  end

  // receive synchronizer, shift register and buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta     <= 1'b1;
      rxLine     <= 1'b1;
      rxSh       <= '0;
      rxParBit   <= 1'b0;
      rxData     <= '0;
      rxReady    <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      rxMeta <= rxd;
      rxLine <= rxMeta;
      if (strobe.rxStart) rxSh <= '0;
      else if (strobe.rxShift) rxSh <= {rxLine, rxSh[BYTE_W-1:1]};
      if (strobe.rxParSample) rxParBit <= rxLine;

      if (strobe.rxDone) begin
        rxData  <= rxWord;
        rxReady <= 1'b1;
      end else if (rxTake) begin
        rxReady <= 1'b0;
      end

      if (strobe.rxDone && rxReady && !rxTake) overrun <= 1'b1;
      else if (errClr) overrun <= 1'b0;

      if (strobe.rxDone && parEn && (rxParBit != parExp)) parityErr <= 1'b1;
      else if (errClr) parityErr <= 1'b0;

      if (strobe.rxDone && !rxLine) framingErr <= 1'b1;
      else if (errClr) framingErr <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_engine.sv
module uart_engine
  import uart_eng_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] wrData,
  input  logic       divLoWr,
  input  logic       divHiWr,
  input  logic       txHoldWr,
  input  logic       rxTake,
  input  logic       errClr,
  input  logic [4:0] lineCfg,
  input  logic       rxd,
  output logic       txd,
  output logic [7:0] rxData,
  output logic       rxReady,
  output logic       holdEmpty,
  output logic       txEmpty,
  output logic       parityErr,
  output logic       framingErr,
  output logic       overrun
);

  engStrobe_t strobe;
  logic       holdFull, txIdle, rxLine;

  uart_eng_ctrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrData(wrData), .divLoWr(divLoWr), .divHiWr(divHiWr),
    .lineCfg(lineCfg), .holdFull(holdFull), .rxLine(rxLine),
    .strobe(strobe), .txIdle(txIdle)
  );

  uart_eng_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineCfg(lineCfg), .wrData(wrData),
    .txHoldWr(txHoldWr), .rxTake(rxTake), .errClr(errClr), .rxd(rxd),
    .txd(txd), .rxLine(rxLine), .holdFull(holdFull), .rxData(rxData),
    .rxReady(rxReady), .parityErr(parityErr), .framingErr(framingErr), .overrun(overrun)
  );

  assign holdEmpty = !holdFull;
  assign txEmpty   = txIdle && !holdFull;

endmodule

// File: rtl/uart_engine_chk.sv
module uart_engine_chk (
  input logic clk,
  input logic rstN,
  input logic txHoldWr,
  input logic rxTake,
  input logic errClr,
  input logic txd,
  input logic rxReady,
  input logic holdEmpty,
  input logic txEmpty,
  input logic parityErr,
  input logic framingErr,
  input logic overrun
);

  a_r7_quiet_means_hold_free: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty);

  a_r7_quiet_line_high: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txd);

  a_r8_write_fills_hold: assert property (@(posedge clk) disable iff (!rstN)
    txHoldWr |=> !holdEmpty);

  a_r10_ready_falls_on_take: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> $past(rxTake));

  a_r11_parity_with_char: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> rxReady);

  a_r11_framing_with_char: assert property (@(posedge clk) disable iff (!rstN)
    $rose(framingErr) |-> rxReady);

  a_r11_framing_clears_on_clr: assert property (@(posedge clk) disable iff (!rstN)
    $fell(framingErr) |-> $past(errClr));

  a_r12_overrun_needs_unread: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(rxReady) && !$past(rxTake)));

endmodule

bind uart_engine uart_engine_chk i_chk (
  .clk(clk), .rstN(rstN), .txHoldWr(txHoldWr), .rxTake(rxTake), .errClr(errClr),
  .txd(txd), .rxReady(rxReady), .holdEmpty(holdEmpty), .txEmpty(txEmpty),
  .parityErr(parityErr), .framingErr(framingErr), .overrun(overrun)
);

// File: tb/test_uart_engine.sv
module test_uart_engine;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] wrData = '0;
  logic       divLoWr = 1'b0, divHiWr = 1'b0, txHoldWr = 1'b0, rxTake = 1'b0, errClr = 1'b0;
  logic [4:0] lineCfg = 5'b00011;
  logic       rxd = 1'b1;
  logic       txd, rxReady, holdEmpty, txEmpty, parityErr, framingErr, overrun;
  logic [7:0] rxData;

  int compared = 0;
  int mismatched = 0;
  int curDiv = 4;
  bit monBusy = 1'b0;

  typedef struct {
    logic [7:0] data;
    int         n;
    bit         parEn;
    bit         parBit;
    int         bitClk;
    int         frameClk;
  } txExp_t;

  txExp_t txQ[$];

  uart_engine i_uart_engine (
    .clk(clk), .rstN(rstN), .wrData(wrData), .divLoWr(divLoWr), .divHiWr(divHiWr),
    .txHoldWr(txHoldWr), .rxTake(rxTake), .errClr(errClr), .lineCfg(lineCfg), .rxd(rxd),
    .txd(txd), .rxData(rxData), .rxReady(rxReady), .holdEmpty(holdEmpty), .txEmpty(txEmpty),
    .parityErr(parityErr), .framingErr(framingErr), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic setDiv(input int v);
    @(negedge clk); wrData = v[7:0];  divLoWr = 1'b1;
    @(negedge clk); divLoWr = 1'b0; wrData = v[15:8]; divHiWr = 1'b1;
    @(negedge clk); divHiWr = 1'b0;
  endtask

  // driver: write a byte and push the frame the line should carry
  task automatic sendTx(input logic [7:0] d);
    txExp_t e;
    int n = 5 + int'(lineCfg[1:0]);
    int stopTicks;
    logic [7:0] m = d & 8'((1 << n) - 1);
    e.data   = m;
    e.n      = n;
    e.parEn  = lineCfg[3];
    e.parBit = lineCfg[4] ? ^m : ~^m;
    e.bitClk = 16 * curDiv;
    stopTicks = !lineCfg[2] ? 16 : (n == 5 ? 24 : 32);
    e.frameClk = 16 * curDiv * (1 + n + (e.parEn ? 1 : 0)) + stopTicks * curDiv;
    txQ.push_back(e);
    @(negedge clk); wrData = d; txHoldWr = 1'b1;
    @(negedge clk); txHoldWr = 1'b0;
  endtask

  task automatic waitTxDone();
    @(negedge clk);
    while (monBusy || txQ.size() != 0 || !txEmpty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic waitStart();
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
  endtask

  task automatic driveRx(input logic [7:0] d, input bit flipPar, input bit badStop);
    int n = 5 + int'(lineCfg[1:0]);
    int bitC = 16 * curDiv;
    logic [7:0] m = d & 8'((1 << n) - 1);
    @(negedge clk); rxd = 1'b0;
    repeat (bitC) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = m[i];
      repeat (bitC) @(negedge clk);
    end
    if (lineCfg[3]) begin
      rxd = (lineCfg[4] ? ^m : ~^m) ^ flipPar;
      repeat (bitC) @(negedge clk);
    end
    rxd = !badStop;
    repeat (bitC) @(negedge clk);
    rxd = 1'b1;
    repeat (bitC) @(negedge clk);
  endtask

  task automatic pulseTake();
    @(negedge clk); rxTake = 1'b1;
    @(negedge clk); rxTake = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
  endtask

  // monitor: decode txd and compare against the queue
  initial begin : txMon
    bit pend;
    int cnt, bits, len, idx;
    logic [7:0] got;
    txExp_t e;
    pend = 1'b0;
    forever begin
      if (!pend) begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
      end
      pend = 1'b0;
      monBusy = 1'b1;
      if (txQ.size() == 0) begin
        chk("R3", "unexpected frame on txd", 1, 0);
        while (txd !== 1'b1) @(negedge clk);
        monBusy = 1'b0;
      end else begin
        e = txQ.pop_front();
        bits = 2 + e.n + (e.parEn ? 1 : 0);
        got = '0;
        cnt = 0;
        len = -1;
        while (len < 0) begin
          if (cnt % e.bitClk == e.bitClk / 2 && cnt / e.bitClk < bits) begin
            idx = cnt / e.bitClk;
            if (idx == 0) chk("R3", "start bit level", int'(txd), 0);
            else if (idx <= e.n) got[idx-1] = txd;
            else if (e.parEn && idx == e.n + 1) chk("R5", "parity bit", int'(txd), int'(e.parBit));
            else chk("R6", "first stop level", int'(txd), 1);
          end
          if (cnt > (bits - 1) * e.bitClk + e.bitClk / 2) begin
            if (txd == 1'b0) begin len = cnt; pend = 1'b1; end
            else if (txEmpty) len = cnt + 1;
          end
          if (len < 0) begin
            @(negedge clk);
            cnt++;
          end
        end
        chk("R4", "tx data LSB first", int'(got), int'(e.data));
        chk("R6", "frame length in clocks", len, e.frameClk);
        monBusy = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7", "reset txd", int'(txd), 1);
    chk("R7", "reset holdEmpty", int'(holdEmpty), 1);
    chk("R7", "reset txEmpty", int'(txEmpty), 1);
    chk("R10", "reset rxReady", int'(rxReady), 0);
    chk("R11", "reset errors", int'({parityErr, framingErr, overrun}), 0);

    // R1: divisor zero after reset holds the byte
    lineCfg = 5'b00011;
    curDiv = 4;
    sendTx(8'hA5);
    repeat (3000) @(negedge clk);
    chk("R1", "txd with zero divisor", int'(txd), 1);
    chk("R1", "holdEmpty with zero divisor", int'(holdEmpty), 0);
    setDiv(4);
    waitStart();
    chk("R7", "holdEmpty at start bit", int'(holdEmpty), 1);
    chk("R7", "txEmpty during frame", int'(txEmpty), 0);
    waitTxDone();

    // R8: back-to-back write during shift
    sendTx(8'h3C);
    waitStart();
    sendTx(8'hC3);
    chk("R8", "holdEmpty after write while shifting", int'(holdEmpty), 0);
    chk("R7", "txEmpty while byte held", int'(txEmpty), 0);
    waitTxDone();

    // R3/R5/R6 formats
    lineCfg = 5'b11010; sendTx(8'h5B); waitTxDone();   // 7 bits even parity
    lineCfg = 5'b01101; sendTx(8'h2D); waitTxDone();   // 6 bits odd parity two stop
    lineCfg = 5'b00100; sendTx(8'h16); waitTxDone();   // 5 bits, 1.5 stop
    lineCfg = 5'b11111; sendTx(8'h81); waitTxDone();   // 8 bits even parity two stop

    // R2: high byte of divisor
    curDiv = 256;
    setDiv(256);
    lineCfg = 5'b00000;
    sendTx(8'h15);
    waitTxDone();
    curDiv = 4;
    setDiv(4);

    // R10/R4 receive 8 bits
    lineCfg = 5'b00011;
    driveRx(8'h5A, 1'b0, 1'b0);
    chk("R10", "rxReady after char", int'(rxReady), 1);
    chk("R4", "rx data 8 bit", int'(rxData), 8'h5A);
    chk("R11", "no errors on clean char", int'({parityErr, framingErr, overrun}), 0);
    pulseTake();
    chk("R10", "rxReady after take", int'(rxReady), 0);

    // R4 right justify after a full byte of ones
    driveRx(8'hFF, 1'b0, 1'b0);
    pulseTake();
    lineCfg = 5'b00000;
    driveRx(8'h11, 1'b0, 1'b0);
    chk("R4", "rx 5-bit right-justified", int'(rxData), 8'h11);
    pulseTake();
    lineCfg = 5'b01001;
    driveRx(8'h2B, 1'b0, 1'b0);
    chk("R4", "rx 6-bit odd parity data", int'(rxData), 8'h2B);
    chk("R5", "no parity error odd", int'(parityErr), 0);
    pulseTake();

    // R11 parity error
    lineCfg = 5'b11010;
    driveRx(8'h47, 1'b1, 1'b0);
    chk("R11", "parityErr on flipped bit", int'(parityErr), 1);
    chk("R11", "data still delivered", int'(rxData), 8'h47);
    pulseClr();
    chk("R11", "parityErr after clear", int'(parityErr), 0);
    pulseTake();

    // R11 framing error
    lineCfg = 5'b00011;
    driveRx(8'h99, 1'b0, 1'b1);
    chk("R11", "framingErr on low stop", int'(framingErr), 1);
    chk("R10", "rxReady with framing error", int'(rxReady), 1);
    pulseClr();
    chk("R11", "framingErr after clear", int'(framingErr), 0);
    pulseTake();

    // R12 overrun
    driveRx(8'h11, 1'b0, 1'b0);
    chk("R12", "no overrun after first", int'(overrun), 0);
    driveRx(8'h22, 1'b0, 1'b0);
    chk("R12", "overrun set", int'(overrun), 1);
    chk("R12", "newest char kept", int'(rxData), 8'h22);
    pulseClr();
    chk("R12", "overrun cleared", int'(overrun), 0);
    chk("R10", "rxReady kept by clear", int'(rxReady), 1);
    pulseTake();

    // R9 short glitch ignored, then a real char
    @(negedge clk); rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (1200) @(negedge clk);
    chk("R9", "glitch gives no char", int'(rxReady), 0);
    driveRx(8'hC6, 1'b0, 1'b0);
    chk("R9", "char after glitch", int'(rxData), 8'hC6);
    chk("R9", "no framing after glitch", int'(framingErr), 0);
    pulseTake();

    repeat (20) @(negedge clk);
    summary();
    $finish;
  end

endmodule